// File: doc/BRIEF.md
# Read-Only Serial EEPROM Target (I2C)

This block is an I2C target that answers like a serial EEPROM with a 16-bit memory address. The image it serves is fixed and read-only, and a parameter sets its contents. The block samples SCL and SDA with a fast system clock, filters both lines and recognises START, repeated START and STOP. It acknowledges one fixed 7-bit address.

In a write transfer the controller loads a two-byte memory pointer. A read transfer then returns image bytes from that pointer. The block supports current-address, random and sequential reads.

The block has no SCL output, so it can never stretch the clock. Each outgoing byte is fetched on the SCL falling edge that ends the ACK clock, so it is ready at once at standard-mode rates. SDA is pulled low through an output enable and is otherwise released. The pointer wraps to zero at the image size. A sticky flag rises once the final image byte has gone out.

Top module: `i2c_rom_target`

## Requirements
- R1: The block acknowledges only the 7-bit address given by `DEV_ADDR` (default 0x50). The address is sent MSB first, followed by a direction bit where 1 means read. For any other address it gives no ACK and keeps SDA released until the next START.
- R2: In a write transfer, the first byte after the address becomes bits 15:8 of the memory pointer and the second becomes bits 7:0. Both bytes are ACKed.
- R3: A third or later byte written in the same transfer gets no ACK. It changes neither the pointer nor the image.
- R4: In a read transfer, each byte sent is the image byte at the pointer, and the pointer then advances by one. This covers a read after a repeated START and a current-address read that continues from the previous transfer.
- R5: While the controller ACKs a read byte, the next byte follows. When the controller NACKs, the block releases SDA and waits for a START. SDA is driven only during an ACK bit or a read data bit.
- R6: Before each fetch, a pointer at or above `IMG_LEN` is reset to zero. This applies both to a pointer that was written and to a sequential read that runs past the end.
- R7: SDA is only ever pulled low, and the output enable changes only while SCL is low. Data goes out MSB first. The block has no way to hold SCL.
- R8: A STOP or START at any point ends the current transfer. After a STOP the block releases SDA and waits for an address.
- R9: `done` rises after the byte at index `IMG_LEN`-1 has been sent. It stays high until reset.
- R10: After reset, SDA is released, `done` is low and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| done | output | 1 | Sticky flag: last image byte has been sent |

## Verification
Two functions can land in the same SCL falling edge: releasing the ACK slot and fetching the next byte, which includes the pointer wrap. The bench provokes this with a sequential read that runs across the end of the image, and with a written pointer above the image size followed by a repeated START. It judges the result by the bytes seen on the bus against a queue of expected image values, and by `done` rising exactly at the last index.

A STOP in the middle of an address byte is also driven. The bench judges it through the pointer value that a following current-address read returns.

// File: rtl/rom_tgt_pkg.sv
package rom_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } tgt_state_e;

  // Pointer correction applied before every fetch.
  function automatic logic [15:0] wrap_ptr(input logic [15:0] p, input int unsigned len);
    return ({16'd0, p} >= len) ? 16'd0 : p;
  endfunction

  // Two-of-three vote used by the line filter.
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/rom_tgt_filter.sv
module rom_tgt_filter
  import rom_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             win_q;
  logic                   level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '1;
      win_q   <= '1;
      level   <= 1'b1;
      level_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw};
      win_q   <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
      level   <= maj3(win_q);
      level_q <= level;
    end
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;

endmodule

// File: rtl/rom_tgt_ctrl.sv
module rom_tgt_ctrl
  import rom_tgt_pkg::*;
#(
  parameter logic [6:0]          DEV_ADDR = 7'h50,
  parameter int                  IMG_LEN  = 16,
  parameter logic [8*IMG_LEN-1:0] IMG_DATA = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_lvl,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_ev,
  input  logic stop_ev,
  output logic sda_oe,
  output logic done
);
  localparam logic [15:0] LAST_IDX = 16'(IMG_LEN - 1);

  tgt_state_e  state;
  logic [3:0]  bit_cnt;
  logic [7:0]  rx_sh;
  logic [7:0]  tx_sh;
  logic [15:0] ptr;
  logic [1:0]  wr_cnt;
  logic        is_read;
  logic        last_tx;
  logic        ctl_ack;

  logic        byte_full;
  logic        addr_hit;
  logic [15:0] fetch_idx;
  logic [7:0]  fetch_byte;

  assign byte_full = (bit_cnt == 4'd8);
  assign addr_hit  = (rx_sh[7:1] == DEV_ADDR);
  assign fetch_idx = wrap_ptr(ptr, IMG_LEN);

  always_comb fetch_byte = IMG_DATA[{fetch_idx, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      wr_cnt  <= '0;
      is_read <= 1'b0;
      last_tx <= 1'b0;
      ctl_ack <= 1'b0;
      sda_oe  <= 1'b0;
      done    <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      wr_cnt  <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && byte_full) begin
            bit_cnt <= '0;
            if (addr_hit) begin
              sda_oe  <= 1'b1;
              is_read <= rx_sh[0];
              state   <= ST_AACK;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (is_read) begin
              sda_oe  <= ~fetch_byte[7];
              tx_sh   <= {fetch_byte[6:0], 1'b0};
              bit_cnt <= 4'd1;
              ptr     <= fetch_idx + 16'd1;
              last_tx <= (fetch_idx == LAST_IDX);
              state   <= ST_RBYTE;
            end else begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WBYTE;
            end
          end
        end
        ST_WBYTE: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && byte_full) begin
            bit_cnt <= '0;
            if (wr_cnt < 2'd2) begin
              sda_oe <= 1'b1;
              if (wr_cnt == 2'd0) ptr[15:8] <= rx_sh;
              else                ptr[7:0]  <= rx_sh;
              wr_cnt <= wr_cnt + 2'd1;
              state  <= ST_WACK;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WBYTE;
          end
        end
        ST_RBYTE: begin
          if (scl_fall) begin
            if (byte_full) begin
              sda_oe <= 1'b0;
              if (last_tx) done <= 1'b1;
              state  <= ST_RACK;
            end else begin
              sda_oe  <= ~tx_sh[7];
              tx_sh   <= {tx_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ctl_ack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (ctl_ack) begin
              sda_oe  <= ~fetch_byte[7];
              tx_sh   <= {fetch_byte[6:0], 1'b0};
              bit_cnt <= 4'd1;
              ptr     <= fetch_idx + 16'd1;
              last_tx <= (fetch_idx == LAST_IDX);
              state   <= ST_RBYTE;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Output enable may only turn on while SCL is low.
  assert_oe_rise_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // SDA is driven only in an ACK slot or a read data bit.
  assert_oe_in_drive_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == ST_AACK || state == ST_WACK || state == ST_RBYTE));

  // Written bytes accepted never exceed two.
  assert_wr_count_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= 2'd2);

  // A STOP leaves the bus released and the engine idle.
  assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_oe));

  // Completion flag is sticky.
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(done));

endmodule

// File: rtl/i2c_rom_target.sv
module i2c_rom_target
  import rom_tgt_pkg::*;
#(
  parameter logic [6:0]           DEV_ADDR    = 7'h50,
  parameter int                   IMG_LEN     = 16,
  parameter logic [8*IMG_LEN-1:0] IMG_DATA    = 128'h01C0ADDE99667E81F00F3CA521444952,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic done
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_v;
  logic [LINES-1:0] lvl_v;
  logic [LINES-1:0] rise_v;
  logic [LINES-1:0] fall_v;

  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    rom_tgt_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_v[g]),
      .level (lvl_v[g]),
      .rise  (rise_v[g]),
      .fall  (fall_v[g])
    );
  end

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_lvl  = lvl_v[0];
  assign sda_lvl  = lvl_v[1];
  assign scl_rise = rise_v[0];
  assign scl_fall = fall_v[0];
  assign start_ev = fall_v[1] & scl_lvl;
  assign stop_ev  = rise_v[1] & scl_lvl;

  rom_tgt_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .IMG_LEN  (IMG_LEN),
    .IMG_DATA (IMG_DATA)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .done     (done)
  );

endmodule

// File: tb/i2c_rom_target_test.sv
module i2c_rom_target_test;
  localparam int Q = 10;
  localparam logic [127:0] BIMG = 128'h01C0ADDE99667E81F00F3CA521444952;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_ctl = 1'b1;
  logic sda_ctl = 1'b1;
  logic sda_oe, done;
  logic sda_line;

  assign sda_line = sda_ctl & ~sda_oe;

  always #4 clk = ~clk;

  i2c_rom_target uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_ctl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .done   (done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int oe_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_q[$];
  bit finished = 0;

  function automatic logic [7:0] img_byte(input int i);
    return BIMG[8*i +: 8];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    hold(Q); sda_ctl = 1'b1; hold(Q); scl_ctl = 1'b1; hold(2*Q);
    sda_ctl = 1'b0; hold(2*Q); scl_ctl = 1'b0;
  endtask

  task automatic bus_stop();
    hold(Q); sda_ctl = 1'b0; hold(Q); scl_ctl = 1'b1; hold(2*Q);
    sda_ctl = 1'b1; hold(2*Q);
  endtask

  task automatic bit_out(input logic b);
    hold(Q); sda_ctl = b; hold(Q); scl_ctl = 1'b1; hold(2*Q); scl_ctl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_ctl = 1'b1; hold(2*Q); scl_ctl = 1'b1; hold(Q); b = sda_line; hold(Q); scl_ctl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    acked = ~b;
  endtask

  // Scoreboard: expected items are queued by push_exp, popped on arrival.
  task automatic push_exp(input logic [7:0] v);
    exp_q.push_back(v);
  endtask

  task automatic recv_byte(input logic give_ack, input string tag);
    logic [7:0] v;
    logic [7:0] e;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    check(tag, v, e);
  endtask

  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_ctl) oe_viol++;
    prev_oe = sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic ak;
    hold(5);
    rst_n = 1'b1;
    hold(2);
    // R10 reset state
    check("R10 sda_oe after reset", sda_oe, 0);
    check("R10 done after reset", done, 0);

    // R1 foreign address ignored
    bus_start();
    send_byte(8'hA2, ak); check("R1 foreign address ack", ak, 0);
    send_byte(8'h00, ak); check("R1 bus released after foreign address", ak, 0);
    bus_stop();

    // R1 R2 pointer load, R4 R5 random sequential read
    bus_start();
    send_byte(8'hA0, ak); check("R1 own address ack", ak, 1);
    send_byte(8'h00, ak); check("R2 high pointer byte ack", ak, 1);
    send_byte(8'h03, ak); check("R2 low pointer byte ack", ak, 1);
    bus_start();
    send_byte(8'hA1, ak); check("R4 read address ack", ak, 1);
    push_exp(img_byte(3)); recv_byte(1'b1, "R4 random read byte");
    push_exp(img_byte(4)); recv_byte(1'b1, "R5 sequential byte 2");
    push_exp(img_byte(5)); recv_byte(1'b0, "R5 sequential byte 3");
    hold(Q);
    check("R5 sda released after NACK", sda_oe, 0);
    bus_stop();

    // R4 current-address read continues
    bus_start();
    send_byte(8'hA1, ak); check("R4 current read ack", ak, 1);
    push_exp(img_byte(6)); recv_byte(1'b0, "R4 current-address byte");
    bus_stop();

    // R2 low byte with zero high byte
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h00, ak); send_byte(8'h0A, ak);
    bus_start();
    send_byte(8'hA1, ak);
    push_exp(img_byte(10)); recv_byte(1'b0, "R2 pointer 0x000A byte");
    bus_stop();

    // R6 written pointer beyond image wraps (and proves high byte stored)
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h01, ak); send_byte(8'h02, ak);
    bus_start();
    send_byte(8'hA1, ak);
    push_exp(img_byte(0)); recv_byte(1'b0, "R6 wrap of pointer 0x0102");
    bus_stop();

    // R9 done low before last byte, R6 sequential wrap
    check("R9 done before last byte", done, 0);
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h00, ak); send_byte(8'h0E, ak);
    bus_start();
    send_byte(8'hA1, ak);
    push_exp(img_byte(14)); recv_byte(1'b1, "R6 byte at 14");
    check("R9 done before index 15 sent", done, 0);
    push_exp(img_byte(15)); recv_byte(1'b1, "R6 byte at 15");
    check("R9 done after last byte", done, 1);
    push_exp(img_byte(0)); recv_byte(1'b1, "R6 sequential wrap to 0");
    push_exp(img_byte(1)); recv_byte(1'b0, "R6 byte after wrap");
    bus_stop();

    // R8 STOP inside an address byte
    bus_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    bus_stop();
    check("R8 sda released after abort", sda_oe, 0);
    bus_start();
    send_byte(8'hA1, ak); check("R8 address ack after abort", ak, 1);
    push_exp(img_byte(2)); recv_byte(1'b0, "R8 pointer kept after abort");
    bus_stop();

    // R3 third written byte refused, nothing changed
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h00, ak); send_byte(8'h07, ak);
    send_byte(8'h5A, ak); check("R3 third written byte nack", ak, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA1, ak);
    push_exp(img_byte(7)); recv_byte(1'b0, "R3 image and pointer unchanged");
    bus_stop();
    check("R9 done still high", done, 1);

    // R7 enable changes only with SCL low
    check("R7 sda_oe changes while SCL high", oe_viol, 0);
    report();
  end

endmodule